// File: doc/BRIEF.md
# Periodic Wake-up Scan Controller

This block lets a receiver spend most of its time switched off. It counts coarse 10 ms ticks to decide when to scan. At each scan it enables the receiver for a short first listening window, counted in 1 ms ticks. If the demodulator reports a header during that window, listening continues for an extended window so that an address can be compared. A matching address raises a wake-up interrupt to the host. The interrupt stays asserted until the host acknowledges it.

The two tick strobes come from slow timers elsewhere on the chip. The period only has to be accurate to about ±20%, so one tick of jitter is acceptable. The header and address strobes are single-cycle pulses from the correlator. The window length and the extension multiple are captured when each scan starts. The period setting is read live.

Top module: `wakeup_scan_ctrl`

## Requirements
- R1: After reset the block is in the sleep state. `scan_state` is 0, and `rx_en` and `wake_irq` are low.
- R2: From reset, or from the start of the previous scan, a scan begins on the `tick_10ms` pulse that completes `period_cfg` ticks. A value of 0 counts as 1. A scan moves the block to the first window (`scan_state` 1).
- R3: The period counter counts from the start of each scan, including ticks that fall inside a listening window. If the period completes while a window is still open, that window runs on unchanged, the missed scan is dropped, and a new period begins.
- R4: The first window lasts `win1_cfg` pulses of `tick_1ms`, where 0 counts as 1. If no header arrives in that time, the block returns to sleep.
- R5: A header strobe in the first window, with a nonzero multiple, enters the extended window (`scan_state` 2). The extended window lasts `ext_mult_cfg` times the window length in 1 ms ticks, and then the block returns to sleep.
- R6: A header strobe in the first window with a multiple of 0 returns the block to sleep.
- R7: An address strobe in the extended window, or one in the same cycle as the header in the first window, enters the wake state (`scan_state` 3). An address strobe alone in the first window has no effect.
- R8: In the wake state `wake_irq` stays high and all ticks are ignored until `irq_ack` is seen. The acknowledge returns the block to sleep, and a fresh period starts from zero.
- R9: `rx_en` is high exactly when `scan_state` is 1 or 2.
- R10: Strobes and acknowledges received in the sleep state have no effect. A header received in the extended window has no effect. The window length used by a scan is the one present when that scan started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_10ms | input | 1 | One-cycle pulse every 10 ms |
| tick_1ms | input | 1 | One-cycle pulse every 1 ms |
| period_cfg | input | 15 | Scan period in 10 ms ticks |
| win1_cfg | input | 10 | First window length in 1 ms ticks |
| ext_mult_cfg | input | 5 | Extended window as a multiple of the first |
| hdr_seen | input | 1 | Header detected strobe |
| addr_ok | input | 1 | Address match strobe |
| irq_ack | input | 1 | Host acknowledge of the interrupt |
| rx_en | output | 1 | Receiver enable |
| wake_irq | output | 1 | Wake-up interrupt |
| scan_state | output | 2 | 0 sleep, 1 first window, 2 extended window, 3 wake |

## Verification
Every internal error surfaces on `scan_state` one clock after the tick or strobe that should have caused a transition. The checks therefore sample one cycle after each stimulus.

- An off-by-one in a window counter shows up as a state change one 1 ms tick early or late. The bench counts ticks up to the exact boundary and one past it.
- A period counter that restarts at the wrong moment delays or advances the next scan by whole 10 ms ticks.
- A lost latch of the multiple changes the length of the extended window.
- A stale state in wake shows up as a missing or sticky interrupt.

// File: rtl/wakeup_scan_ctrl.sv
module wakeup_scan_ctrl #(
  parameter int PER_W = 15,
  parameter int WIN_W = 10,
  parameter int MUL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_10ms,
  input  logic             tick_1ms,
  input  logic [PER_W-1:0] period_cfg,
  input  logic [WIN_W-1:0] win1_cfg,
  input  logic [MUL_W-1:0] ext_mult_cfg,
  input  logic             hdr_seen,
  input  logic             addr_ok,
  input  logic             irq_ack,
  output logic             rx_en,
  output logic             wake_irq,
  output logic [1:0]       scan_state
);

  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_LIST1 = 2'd1,
    ST_LIST2 = 2'd2,
    ST_WAKE  = 2'd3
  } scan_st_t;

  scan_st_t state_q, state_d;

  logic [PER_W-1:0] per_cnt;
  logic [WIN_W-1:0] win_cnt, win_lat;
  logic [MUL_W-1:0] mul_cnt, mult_lat;

  wire [PER_W-1:0] per_eff = (period_cfg == '0) ? PER_W'(1) : period_cfg;
  wire [WIN_W-1:0] win_eff = (win1_cfg == '0) ? WIN_W'(1) : win1_cfg;

  wire per_hit  = tick_10ms && (({1'b0, per_cnt} + 1'b1) >= {1'b0, per_eff});
  wire win_hit  = tick_1ms && (({1'b0, win_cnt} + 1'b1) >= {1'b0, win_lat});
  wire last_mul = ({1'b0, mul_cnt} + 1'b1) >= {1'b0, mult_lat};
  wire listening = (state_q == ST_LIST1) || (state_q == ST_LIST2);
  wire scan_go  = (state_q == ST_SLEEP) && per_hit;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_SLEEP: if (per_hit) state_d = ST_LIST1;
      ST_LIST1: begin
        if (hdr_seen) begin
          if (addr_ok)               state_d = ST_WAKE;
          else if (mult_lat == '0)   state_d = ST_SLEEP;
          else                       state_d = ST_LIST2;
        end else if (win_hit) begin
          state_d = ST_SLEEP;
        end
      end
      ST_LIST2: begin
        if (addr_ok)                 state_d = ST_WAKE;
        else if (win_hit && last_mul) state_d = ST_SLEEP;
      end
      default: if (irq_ack) state_d = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SLEEP;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
    end else if (state_q == ST_WAKE) begin
      per_cnt <= '0;
    end else if (tick_10ms) begin
      per_cnt <= per_hit ? '0 : per_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_lat  <= WIN_W'(1);
      mult_lat <= '0;
    end else if (scan_go) begin
      win_lat  <= win_eff;
      mult_lat <= ext_mult_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      mul_cnt <= '0;
    end else if (state_d != state_q) begin
      win_cnt <= '0;
      mul_cnt <= '0;
    end else if (listening && tick_1ms) begin
      if (win_hit) begin
        win_cnt <= '0;
        mul_cnt <= mul_cnt + 1'b1;
      end else begin
        win_cnt <= win_cnt + 1'b1;
      end
    end
  end

  assign rx_en      = listening;
  assign wake_irq   = (state_q == ST_WAKE);
  assign scan_state = state_q;

  // R2
  scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LIST1 && $past(state_q) == ST_SLEEP) |-> $past(tick_10ms));

  // R4
  win_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    listening |-> (win_cnt < win_lat));

  // R5
  listen2_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LIST2 && $past(state_q) != ST_LIST2) |-> ($past(hdr_seen) && $past(state_q) == ST_LIST1));

  // R5
  mul_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LIST2) |-> (mul_cnt < mult_lat));

  // R7
  wake_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq) |-> $past(addr_ok));

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && !irq_ack) |=> wake_irq);

  // R8
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && irq_ack) |=> (!wake_irq && scan_state == 2'd0));

endmodule

// File: tb/wakeup_scan_ctrl_tb.sv
module wakeup_scan_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // win, mult, header after N ms (255 none), addr with header, addr after N ms in ext (255 none), expected final state
  localparam int VEC [NV][6] = '{
    '{3, 0, 255, 0, 255, 0},
    '{0, 0, 255, 0, 255, 0},
    '{4, 2, 1,   0, 255, 0},
    '{4, 2, 3,   0, 5,   3},
    '{2, 0, 1,   0, 255, 0},
    '{2, 0, 0,   1, 255, 3},
    '{5, 31, 0,  1, 255, 3},
    '{1, 3, 0,   0, 2,   3}
  };

  logic clk = 0, rst_n = 0, tick_10ms = 0, tick_1ms = 0;
  logic [14:0] period_cfg = 1;
  logic [9:0]  win1_cfg = 1;
  logic [4:0]  ext_mult_cfg = 0;
  logic hdr_seen = 0, addr_ok = 0, irq_ack = 0;
  logic rx_en, wake_irq;
  logic [1:0] scan_state;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wakeup_scan_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tick_10ms(tick_10ms), .tick_1ms(tick_1ms),
    .period_cfg(period_cfg), .win1_cfg(win1_cfg), .ext_mult_cfg(ext_mult_cfg),
    .hdr_seen(hdr_seen), .addr_ok(addr_ok), .irq_ack(irq_ack),
    .rx_en(rx_en), .wake_irq(wake_irq), .scan_state(scan_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int per, input int win, input int mult);
    @(negedge clk);
    rst_n = 0;
    period_cfg = 15'(per);
    win1_cfg = 10'(win);
    ext_mult_cfg = 5'(mult);
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t10(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_10ms = 1;
      @(negedge clk) tick_10ms = 0;
    end
  endtask

  task automatic tms(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_1ms = 1;
      @(negedge clk) tick_1ms = 0;
    end
  endtask

  task automatic strobe(input logic h, input logic a, input logic k);
    @(negedge clk);
    hdr_seen = h; addr_ok = a; irq_ack = k;
    @(negedge clk);
    hdr_seen = 0; addr_ok = 0; irq_ack = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(3, 2, 0);
    @(negedge clk);
    chk("R1 state", scan_state, 0);
    chk("R1 rx_en", rx_en, 0);
    chk("R1 irq", wake_irq, 0);

    // R2 period of three ticks
    t10(2);
    chk("R2 before period", scan_state, 0);
    t10(1);
    chk("R2 scan start", scan_state, 1);
    chk("R9 rx_en in first window", rx_en, 1);

    // R3 ticks inside the window count toward the next period
    do_reset(3, 2, 0);
    t10(3);
    chk("R3 first scan", scan_state, 1);
    t10(1);
    tms(2);
    chk("R3 window end", scan_state, 0);
    t10(1);
    chk("R3 not yet", scan_state, 0);
    t10(1);
    chk("R3 free-running period", scan_state, 1);

    // R3 period expiring inside a window is dropped
    do_reset(2, 10, 0);
    t10(2);
    chk("R3 overlap start", scan_state, 1);
    t10(2);
    tms(9);
    chk("R3 window kept open", scan_state, 1);
    tms(1);
    chk("R3 window closes", scan_state, 0);
    t10(1);
    chk("R3 new period partial", scan_state, 0);
    t10(1);
    chk("R3 new period scan", scan_state, 1);

    // table walk: R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      int w, m, ha, both, aa, ex;
      w = (VEC[v][0] == 0) ? 1 : VEC[v][0];
      m = VEC[v][1]; ha = VEC[v][2]; both = VEC[v][3]; aa = VEC[v][4]; ex = VEC[v][5];
      do_reset(1, VEC[v][0], m);
      t10(1);
      chk("R2 table scan start", scan_state, 1);
      if (ha == 255) begin
        tms(w - 1);
        chk("R4 window still open", scan_state, 1);
        tms(1);
        chk("R4 window expiry", scan_state, ex);
      end else begin
        tms(ha);
        strobe(1, both[0], 0);
        if (both != 0) begin
          chk("R7 header with address", scan_state, 3);
          chk("R7 irq", wake_irq, 1);
        end else if (m == 0) begin
          chk("R6 zero multiple", scan_state, 0);
        end else begin
          chk("R5 extended entry", scan_state, 2);
          chk("R9 rx_en extended", rx_en, 1);
          if (aa == 255) begin
            tms(m * w - 1);
            chk("R5 extended still open", scan_state, 2);
            tms(1);
            chk("R5 extended expiry", scan_state, ex);
          end else begin
            tms(aa);
            strobe(0, 1, 0);
            chk("R7 address match", scan_state, ex);
            chk("R7 irq after match", wake_irq, 1);
          end
        end
      end
    end

    // R8 interrupt held until acknowledge, period restarts
    do_reset(2, 4, 1);
    t10(2);
    strobe(1, 0, 0);
    strobe(0, 1, 0);
    chk("R8 wake", scan_state, 3);
    chk("R9 rx_en off in wake", rx_en, 0);
    t10(3);
    tms(5);
    strobe(1, 0, 0);
    chk("R8 held state", scan_state, 3);
    chk("R8 held irq", wake_irq, 1);
    strobe(0, 0, 1);
    chk("R8 ack state", scan_state, 0);
    chk("R8 ack irq", wake_irq, 0);
    t10(1);
    chk("R8 fresh period partial", scan_state, 0);
    t10(1);
    chk("R8 fresh period scan", scan_state, 1);

    // R10 strobes ignored in sleep; R7 address alone ignored in first window
    do_reset(2, 3, 2);
    strobe(1, 1, 1);
    chk("R10 sleep strobes", scan_state, 0);
    chk("R10 sleep irq", wake_irq, 0);
    t10(2);
    strobe(0, 1, 0);
    chk("R7 lone address", scan_state, 1);
    // R10 window length captured at scan start
    win1_cfg = 10;
    tms(2);
    chk("R10 captured window open", scan_state, 1);
    tms(1);
    chk("R10 captured window", scan_state, 0);

    // R10 header in extended window ignored
    do_reset(1, 2, 2);
    t10(1);
    strobe(1, 0, 0);
    tms(2);
    strobe(1, 0, 0);
    tms(1);
    chk("R10 ext header ignored", scan_state, 2);
    tms(1);
    chk("R10 ext length unchanged", scan_state, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule